// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between a 32-bit integer pipeline and a 64-bit wide data memory. For each accepted load/store instruction it forms the effective address, checks natural alignment, and then drives one memory beat. Stores get their data moved into the correct byte lanes with matching byte enables. Loads get the addressed bytes pulled out of the returned doubleword and widened to 32 bits, with sign or zero fill. Doubleword transfers move an even/odd register pair.

The memory is big-endian and answers a read one cycle after the request. A load therefore finishes one cycle after it is accepted. Two atomic operations are supported. Byte test-and-set returns the old byte and writes all ones. Word swap exchanges a register with memory. Each atomic runs as a locked read beat followed directly by a locked write beat to the same doubleword. A misaligned access raises an exception in its request cycle and goes no further.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `rs1_val` plus, when instruction bit 13 is 1, the sign-extended 13-bit field in bits 12:0, otherwise plus `rs2_val`. `mem_addr` carries this address with bits 2:0 cleared, in the cycle the request is accepted.
- R2: An operation is recognised only when bits 31:30 equal 3. The 6-bit code in bits 24:19 then selects one of these: 0 word load, 1 unsigned byte load, 2 unsigned half load, 3 pair load, 4 word store, 5 byte store, 6 half store, 7 pair store, 9 signed byte load, 10 signed half load, 13 byte test-and-set, 15 word swap. Any other instruction raises no request, no exception and no writeback.
- R3: Lanes are big-endian. Byte offset o (address bits 2:0) occupies `mem_be[7-o]` and data bits 63-8o down to 56-8o.
- R4: A byte, half or word store enables only the lanes it covers and places the low bits of `rd_val` in them. A pair store enables all eight lanes, with `rd_val` in bits 63:32 and `rd_pair_val` in bits 31:0. A store produces no writeback.
- R5: A load asserts `wb_valid` one cycle after acceptance, with `wb_rd` equal to bits 29:25 of the instruction. Unsigned byte and half loads zero-fill bits 31 up.
- R6: Signed byte and half loads copy the top bit of the loaded item into all higher bits of `wb_data`.
- R7: A pair load returns memory bits 63:32 on `wb_data` and bits 31:0 on `wb_data_hi`, with `wb_pair` high. `wb_pair` is low for every other response.
- R8: `exc_misalign` pulses in the request cycle, with no memory request and no later writeback, in three cases. The first is a half access at an odd address. The second is a word or swap access whose address bits 1:0 are not 0. The third is a pair access whose address bits 2:0 are not 0, or whose destination register number (bits 29:25) is odd. Byte accesses never fault.
- R9: Test-and-set issues a read beat with `mem_lock`, then in the next cycle a write beat with `mem_lock` to the same address. The write enables only the addressed byte lane and writes 0xFF there. In the write cycle `wb_data` returns the old byte, zero-extended.
- R10: Swap issues the same locked read-then-write pair. The write places the `rd_val` captured at acceptance in the word lanes, and `wb_data` returns the old memory word.
- R11: `busy` is high in the cycle after an accepted load or atomic. While `busy` is high, `req_valid` is ignored, and during a load's response cycle no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction presented this cycle |
| insn | input | 32 | Instruction word |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Index register value |
| rd_val | input | 32 | Value of register rd (store/swap data) |
| rd_pair_val | input | 32 | Value of register rd+1 (pair store) |
| busy | output | 1 | Second cycle of a multi-cycle operation |
| exc_misalign | output | 1 | Alignment exception |
| wb_valid | output | 1 | Writeback result valid |
| wb_rd | output | 5 | Destination register number |
| wb_data | output | 32 | Result for rd |
| wb_data_hi | output | 32 | Result for rd+1 on pair loads |
| wb_pair | output | 1 | Writeback covers the register pair |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_lock | output | 1 | Beat belongs to an atomic pair |
| mem_addr | output | 32 | Doubleword-aligned address |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read |

## Verification
The bench preloads distinctive bytes whose top bits are both set and clear. This lets it tell sign fill from zero fill, a wrong lane from a right one, and the upper half of the doubleword from the lower. Loads are issued at every offset class, through both the register and the negative-immediate address forms, so a wrong adder operand or a wrong lane shift gives visibly different data. Stores of every size are checked on the port and then read back through loads. The atomic pair is checked beat by beat: lock, address, single-lane enable, old value returned. Misaligned addresses, an odd pair register, unrecognised codes and a request held during `busy` all show whether any beat escapes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } lsu_size_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_ATOM  = 2'd3
  } lsu_kind_e;

  typedef struct packed {
    lsu_kind_e kind;
    lsu_size_e size;
    logic      sext;
    logic      set_ff;
  } lsu_op_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_ATOM = 2'd2
  } lsu_state_e;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [31:0] insn,
  output lsu_op_t     op
);

  function automatic lsu_op_t mk(lsu_kind_e k, lsu_size_e s, logic x, logic f);
    lsu_op_t r;
    r.kind   = k;
    r.size   = s;
    r.sext   = x;
    r.set_ff = f;
    return r;
  endfunction

  always_comb begin
    op = mk(K_NONE, SZ_BYTE, 1'b0, 1'b0);
    if (insn[31:30] == 2'b11) begin
      unique case (insn[24:19])
        6'd0:    op = mk(K_LOAD,  SZ_WORD, 1'b0, 1'b0);
        6'd1:    op = mk(K_LOAD,  SZ_BYTE, 1'b0, 1'b0);
        6'd2:    op = mk(K_LOAD,  SZ_HALF, 1'b0, 1'b0);
        6'd3:    op = mk(K_LOAD,  SZ_DBL,  1'b0, 1'b0);
        6'd4:    op = mk(K_STORE, SZ_WORD, 1'b0, 1'b0);
        6'd5:    op = mk(K_STORE, SZ_BYTE, 1'b0, 1'b0);
        6'd6:    op = mk(K_STORE, SZ_HALF, 1'b0, 1'b0);
        6'd7:    op = mk(K_STORE, SZ_DBL,  1'b0, 1'b0);
        6'd9:    op = mk(K_LOAD,  SZ_BYTE, 1'b1, 1'b0);
        6'd10:   op = mk(K_LOAD,  SZ_HALF, 1'b1, 1'b0);
        6'd13:   op = mk(K_ATOM,  SZ_BYTE, 1'b0, 1'b1);
        6'd15:   op = mk(K_ATOM,  SZ_WORD, 1'b0, 1'b0);
        default: op = mk(K_NONE,  SZ_BYTE, 1'b0, 1'b0);
      endcase
    end
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 13
) (
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  rs2_val,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm,
  input  lsu_size_e        size,
  input  logic             rd_lsb,
  output logic [XLEN-1:0]  ea,
  output logic             misalign
);

  logic [XLEN-1:0] operand_b;

  always_comb begin
    operand_b = imm_sel ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} : rs2_val;
    ea        = rs1_val + operand_b;
    unique case (size)
      SZ_HALF: misalign = ea[0];
      SZ_WORD: misalign = |ea[1:0];
      SZ_DBL:  misalign = (|ea[2:0]) | rd_lsb;
      default: misalign = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  lsu_size_e                        size,
  input  logic [$clog2(2*XLEN/8)-1:0]      off,
  input  logic [XLEN-1:0]                  data_lo,
  input  logic [XLEN-1:0]                  data_hi,
  output logic [2*XLEN/8-1:0]              be,
  output logic [2*XLEN-1:0]                wdata
);

  localparam int MEM_W = 2 * XLEN;
  localparam int NB    = MEM_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W:0]   nbytes;
  logic [OFF_W:0]   lane;
  logic [NB-1:0]    mask;
  logic [XLEN-1:0]  src;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin nbytes = (OFF_W+1)'(1);      src = {{(XLEN-8){1'b0}}, data_lo[7:0]};   end
      SZ_HALF: begin nbytes = (OFF_W+1)'(2);      src = {{(XLEN-16){1'b0}}, data_lo[15:0]}; end
      SZ_WORD: begin nbytes = (OFF_W+1)'(NB/2);   src = data_lo;                            end
      default: begin nbytes = (OFF_W+1)'(NB);     src = data_lo;                            end
    endcase
    lane = (OFF_W+1)'(NB) - nbytes - {1'b0, off};
    for (int i = 0; i < NB; i++) begin
      mask[i] = (i < int'(nbytes));
    end
    be = mask << lane;
    if (size == SZ_DBL) wdata = {data_lo, data_hi};
    else                wdata = MEM_W'(src) << {lane, 3'b000};
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  lsu_size_e                    size,
  input  logic                         sext,
  input  logic [$clog2(2*XLEN/8)-1:0]  off,
  input  logic [2*XLEN-1:0]            rdata,
  output logic [XLEN-1:0]              res_lo,
  output logic [XLEN-1:0]              res_hi
);

  localparam int MEM_W = 2 * XLEN;
  localparam int NB    = MEM_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W:0]   nbytes;
  logic [OFF_W:0]   lane;
  logic [MEM_W-1:0] shifted;

  always_comb begin
    unique case (size)
      SZ_BYTE: nbytes = (OFF_W+1)'(1);
      SZ_HALF: nbytes = (OFF_W+1)'(2);
      SZ_WORD: nbytes = (OFF_W+1)'(NB/2);
      default: nbytes = (OFF_W+1)'(NB);
    endcase
    lane    = (OFF_W+1)'(NB) - nbytes - {1'b0, off};
    shifted = rdata >> {lane, 3'b000};
    res_hi  = '0;
    unique case (size)
      SZ_BYTE: res_lo = {{(XLEN-8){sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: res_lo = {{(XLEN-16){sext & shifted[15]}}, shifted[15:0]};
      SZ_WORD: res_lo = shifted[XLEN-1:0];
      default: begin
        res_lo = rdata[MEM_W-1:XLEN];
        res_hi = rdata[XLEN-1:0];
      end
    endcase
  end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 13,
  parameter int REG_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          insn,
  input  logic [XLEN-1:0]      rs1_val,
  input  logic [XLEN-1:0]      rs2_val,
  input  logic [XLEN-1:0]      rd_val,
  input  logic [XLEN-1:0]      rd_pair_val,
  output logic                 busy,
  output logic                 exc_misalign,
  output logic                 wb_valid,
  output logic [REG_W-1:0]     wb_rd,
  output logic [XLEN-1:0]      wb_data,
  output logic [XLEN-1:0]      wb_data_hi,
  output logic                 wb_pair,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_lock,
  output logic [XLEN-1:0]      mem_addr,
  output logic [2*XLEN/8-1:0]  mem_be,
  output logic [2*XLEN-1:0]    mem_wdata,
  input  logic [2*XLEN-1:0]    mem_rdata
);

  localparam int MEM_W = 2 * XLEN;
  localparam int NB    = MEM_W / 8;
  localparam int OFF_W = $clog2(NB);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lsu_op_t          dec_op;
  logic [XLEN-1:0]  ea;
  logic             misal;
  logic             unused_rs1_idx;

  assign unused_rs1_idx = ^insn[18:14];

  lsu_decode u_dec (
    .insn (insn),
    .op   (dec_op)
  );

  lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .rs1_val  (rs1_val),
    .rs2_val  (rs2_val),
    .imm_sel  (insn[13]),
    .imm      (insn[IMM_W-1:0]),
    .size     (dec_op.size),
    .rd_lsb   (insn[25]),
    .ea       (ea),
    .misalign (misal)
  );

  lsu_state_e       state_q, state_d;
  lsu_op_t          op_q;
  logic [OFF_W-1:0] off_q;
  logic [XLEN-1:0]  addr_q;
  logic [REG_W-1:0] rd_q;
  logic [XLEN-1:0]  data_q;

  logic accept, go, in_atom;
  logic [XLEN-1:0] aligned_ea;

  assign in_atom    = (state_q == S_ATOM);
  assign accept     = (state_q == S_IDLE) && req_valid && (dec_op.kind != K_NONE);
  assign go         = accept && !misal;
  assign aligned_ea = {ea[XLEN-1:OFF_W], {OFF_W{1'b0}}};

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (go && dec_op.kind == K_LOAD) state_d = S_LOAD;
        else if (go && dec_op.kind == K_ATOM) state_d = S_ATOM;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_IDLE;
    else            state_q <= state_d;
  end

  // operation context captured on acceptance
  always_ff @(posedge clk) begin
    if (go) begin
      op_q   <= dec_op;
      off_q  <= ea[OFF_W-1:0];
      addr_q <= aligned_ea;
      rd_q   <= insn[29:25];
      data_q <= rd_val;
    end
  end

  // shared lane placement for stores and the atomic write beat
  lsu_size_e        st_size;
  logic [OFF_W-1:0] st_off;
  logic [XLEN-1:0]  st_lo;

  always_comb begin
    if (in_atom) begin
      st_size = op_q.size;
      st_off  = off_q;
      st_lo   = op_q.set_ff ? {{(XLEN-8){1'b0}}, 8'hFF} : data_q;
    end else begin
      st_size = dec_op.size;
      st_off  = ea[OFF_W-1:0];
      st_lo   = rd_val;
    end
  end

  lsu_store_lane #(.XLEN(XLEN)) u_st (
    .size    (st_size),
    .off     (st_off),
    .data_lo (st_lo),
    .data_hi (rd_pair_val),
    .be      (mem_be),
    .wdata   (mem_wdata)
  );

  lsu_load_extract #(.XLEN(XLEN)) u_ld (
    .size   (op_q.size),
    .sext   (op_q.sext),
    .off    (off_q),
    .rdata  (mem_rdata),
    .res_lo (wb_data),
    .res_hi (wb_data_hi)
  );

  // port outputs
  assign exc_misalign = accept && misal;
  assign mem_req      = go || in_atom;
  assign mem_we       = in_atom || (go && dec_op.kind == K_STORE);
  assign mem_lock     = in_atom || (go && dec_op.kind == K_ATOM);
  assign mem_addr     = in_atom ? addr_q : aligned_ea;
  assign busy         = (state_q != S_IDLE);
  assign wb_valid     = (state_q == S_LOAD) || in_atom;
  assign wb_pair      = (state_q == S_LOAD) && (op_q.size == SZ_DBL);
  assign wb_rd        = rd_q;

endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            exc_misalign,
  input logic            wb_valid,
  input logic            wb_pair,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_lock,
  input logic [XLEN-1:0] mem_addr
);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  p_read_answers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> wb_valid);

  p_pair_only_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pair |-> wb_valid);

  p_fault_no_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_misalign |-> !mem_req);

  p_fault_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_misalign |=> !wb_valid);

  p_lock_write_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_lock && !mem_we) |=> (mem_req && mem_lock && mem_we));

  p_lock_same_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_lock && !mem_we) |=> $stable(mem_addr));

  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_lock) |-> !mem_req);

endmodule

bind lsu_align_unit lsu_align_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/lsu_align_unit_tb.sv
`timescale 1ns/1ps
module lsu_align_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] insn, rs1_val, rs2_val, rd_val, rd_pair_val;
  logic        busy, exc_misalign, wb_valid, wb_pair;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data, wb_data_hi, mem_addr;
  logic        mem_req, mem_we, mem_lock;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  lsu_align_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .insn(insn),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .rd_val(rd_val), .rd_pair_val(rd_pair_val),
    .busy(busy), .exc_misalign(exc_misalign), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .wb_data_hi(wb_data_hi), .wb_pair(wb_pair),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: big-endian lanes, read data one cycle after request
  logic [63:0] mem [0:7];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 8; i++)
          if (mem_be[i]) mem[mem_addr[5:3]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:3]];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op3, input logic [4:0] rd,
                                     input logic isel, input logic [12:0] lo);
    return {2'b11, rd, op3, 5'd0, isel, lo};
  endfunction

  task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] v, input logic [31:0] vh);
    @(negedge clk);
    req_valid = 1'b1; insn = w; rs1_val = a; rs2_val = b; rd_val = v; rd_pair_val = vh;
    #0.5;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_valid = 1'b0;
    #0.5;
  endtask

  // single load at address a (immediate 0), checks request and response
  task automatic load_at(input string tag, input logic [5:0] op3, input logic [4:0] rd,
                         input logic [31:0] a, input logic [31:0] exp_lo,
                         input logic [31:0] exp_hi, input logic exp_pair);
    drive(mk(op3, rd, 1'b1, 13'd0), a, 32'd0, 32'd0, 32'd0);
    chk({tag, " req"}, {61'd0, mem_req, mem_we, exc_misalign}, 64'b100);
    chk({tag, " addr"}, mem_addr, {a[31:3], 3'b000});
    idle_cycle();
    chk({tag, " wb_valid"}, wb_valid, 1'b1);
    chk({tag, " wb_rd"}, wb_rd, rd);
    chk({tag, " data"}, wb_data, exp_lo);
    chk({tag, " pair"}, {wb_pair, wb_data_hi}, {exp_pair, exp_hi});
  endtask

  task automatic test_reset();
    chk("R11 reset busy", busy, 1'b0);
    chk("R11 reset mem_req", mem_req, 1'b0);
    chk("R5 reset wb_valid", wb_valid, 1'b0);
  endtask

  task automatic test_agen();
    // R1: immediate form, negative offset: 16 + (-8) = 8
    drive(mk(6'd0, 5'd1, 1'b1, 13'h1FF8), 32'd16, 32'hFFFF_FFFF, 32'd0, 32'd0);
    chk("R1 imm addr", mem_addr, 32'd8);
    idle_cycle();
    chk("R1 imm data", wb_data, 32'h89AB_CDEF);
    // R1: register form: 4 + 8 = 12, lower word
    drive(mk(6'd0, 5'd2, 1'b0, 13'h1FF8), 32'd4, 32'd8, 32'd0, 32'd0);
    chk("R1 reg addr", mem_addr, 32'd8);
    idle_cycle();
    chk("R1 reg data", wb_data, 32'h0123_4567);
  endtask

  task automatic test_extend();
    load_at("R5 ldub off0",  6'd1,  5'd3, 32'd8,  32'h0000_0089, 32'd0, 1'b0);
    load_at("R6 ldsb off0",  6'd9,  5'd4, 32'd8,  32'hFFFF_FF89, 32'd0, 1'b0);
    load_at("R6 ldsb pos",   6'd9,  5'd5, 32'd12, 32'h0000_0001, 32'd0, 1'b0);
    load_at("R6 ldsh off2",  6'd10, 5'd6, 32'd10, 32'hFFFF_CDEF, 32'd0, 1'b0);
    load_at("R5 lduh off6",  6'd2,  5'd7, 32'd14, 32'h0000_4567, 32'd0, 1'b0);
    load_at("R3 lduh off0",  6'd2,  5'd8, 32'd8,  32'h0000_89AB, 32'd0, 1'b0);
    load_at("R8 ldub off7",  6'd1,  5'd9, 32'd15, 32'h0000_0067, 32'd0, 1'b0);
  endtask

  task automatic test_pair_load();
    load_at("R7 ldd", 6'd3, 5'd6, 32'd16, 32'h1122_3344, 32'h5566_7788, 1'b1);
  endtask

  task automatic test_store();
    drive(mk(6'd5, 5'd1, 1'b1, 13'd0), 32'd27, 32'd0, 32'hABCD_EF5A, 32'd0);
    chk("R3 stb be", mem_be, 8'h10);
    chk("R4 stb data", mem_wdata, 64'h0000_005A_0000_0000);
    chk("R4 stb we", {mem_req, mem_we}, 2'b11);
    idle_cycle();
    chk("R4 no wb after store", wb_valid, 1'b0);
    drive(mk(6'd6, 5'd1, 1'b1, 13'd0), 32'd30, 32'd0, 32'h1234_BEEF, 32'd0);
    chk("R4 sth be", mem_be, 8'h03);
    chk("R4 sth data", mem_wdata, 64'h0000_0000_0000_BEEF);
    drive(mk(6'd4, 5'd1, 1'b1, 13'd0), 32'd28, 32'd0, 32'hDEAD_BEEF, 32'd0);
    chk("R4 st be", mem_be, 8'h0F);
    chk("R4 st data", mem_wdata, 64'h0000_0000_DEAD_BEEF);
    drive(mk(6'd7, 5'd2, 1'b1, 13'd0), 32'd32, 32'd0, 32'hCAFE_F00D, 32'h1357_9BDF);
    chk("R4 std be", mem_be, 8'hFF);
    chk("R4 std data", mem_wdata, 64'hCAFE_F00D_1357_9BDF);
    idle_cycle();
    chk("R4 memory word3", mem[3], 64'h0000_005A_DEAD_BEEF);
    load_at("R4 readback ld", 6'd0, 5'd1, 32'd24, 32'h0000_005A, 32'd0, 1'b0);
    load_at("R4 readback ldd", 6'd3, 5'd10, 32'd32, 32'hCAFE_F00D, 32'h1357_9BDF, 1'b1);
  endtask

  task automatic fault_case(input string tag, input logic [5:0] op3, input logic [4:0] rd,
                            input logic [31:0] a);
    drive(mk(op3, rd, 1'b1, 13'd0), a, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk({tag, " exc/req"}, {exc_misalign, mem_req}, 2'b10);
    idle_cycle();
    chk({tag, " quiet"}, {wb_valid, busy, mem_req}, 3'b000);
  endtask

  task automatic test_misalign();
    fault_case("R8 lduh odd",   6'd2,  5'd1, 32'd9);
    fault_case("R8 ld half",    6'd0,  5'd1, 32'd10);
    fault_case("R8 ldd word",   6'd3,  5'd2, 32'd12);
    fault_case("R8 ldd odd rd", 6'd3,  5'd3, 32'd8);
    fault_case("R8 std odd rd", 6'd7,  5'd5, 32'd16);
    fault_case("R8 swap off2",  6'd15, 5'd1, 32'd18);
    chk("R8 memory untouched", mem[2], 64'h1122_3344_5566_7788);
  endtask

  task automatic test_test_and_set();
    drive(mk(6'd13, 5'd11, 1'b1, 13'd0), 32'd9, 32'd0, 32'h1111_1111, 32'd0);
    chk("R9 read beat", {mem_req, mem_we, mem_lock}, 3'b101);
    chk("R9 read addr", mem_addr, 32'd8);
    idle_cycle();
    chk("R9 write beat", {mem_req, mem_we, mem_lock}, 3'b111);
    chk("R9 write addr", mem_addr, 32'd8);
    chk("R9 write be", mem_be, 8'h40);
    chk("R9 write data", mem_wdata, 64'h00FF_0000_0000_0000);
    chk("R9 old byte", {wb_valid, wb_rd, wb_data}, {1'b1, 5'd11, 32'h0000_00AB});
    idle_cycle();
    chk("R9 lock released", {mem_req, mem_lock, busy}, 3'b000);
    load_at("R9 readback", 6'd0, 5'd1, 32'd8, 32'h89FF_CDEF, 32'd0, 1'b0);
  endtask

  task automatic test_swap();
    drive(mk(6'd15, 5'd12, 1'b1, 13'd0), 32'd20, 32'd0, 32'h0A0B_0C0D, 32'd0);
    chk("R10 read beat", {mem_req, mem_we, mem_lock}, 3'b101);
    idle_cycle();
    chk("R10 write beat", {mem_req, mem_we, mem_lock}, 3'b111);
    chk("R10 write be", mem_be, 8'h0F);
    chk("R10 write data", mem_wdata, 64'h0000_0000_0A0B_0C0D);
    chk("R10 old word", {wb_valid, wb_data}, {1'b1, 32'h5566_7788});
    load_at("R10 readback", 6'd0, 5'd1, 32'd20, 32'h0A0B_0C0D, 32'd0, 1'b0);
  endtask

  task automatic test_decode();
    drive({2'b10, 5'd1, 6'd0, 5'd0, 1'b1, 13'd8}, 32'd8, 32'd0, 32'd0, 32'd0);
    chk("R2 op field 2", {mem_req, exc_misalign}, 2'b00);
    drive(mk(6'd8, 5'd1, 1'b1, 13'd0), 32'd9, 32'd0, 32'd0, 32'd0);
    chk("R2 code 8", {mem_req, exc_misalign}, 2'b00);
    drive(mk(6'd11, 5'd1, 1'b1, 13'd0), 32'd8, 32'd0, 32'd0, 32'd0);
    chk("R2 code 11", {mem_req, exc_misalign}, 2'b00);
    idle_cycle();
    chk("R2 no response", {wb_valid, busy}, 2'b00);
  endtask

  task automatic test_busy();
    drive(mk(6'd0, 5'd1, 1'b1, 13'd0), 32'd16, 32'd0, 32'd0, 32'd0);
    // hold a store request through the response cycle
    drive(mk(6'd4, 5'd1, 1'b1, 13'd0), 32'd16, 32'd0, 32'h7777_7777, 32'd0);
    chk("R11 busy", busy, 1'b1);
    chk("R11 no beat while busy", mem_req, 1'b0);
    chk("R11 load answered", wb_data, 32'h1122_3344);
    idle_cycle();
    chk("R11 store dropped", {mem_req, wb_valid}, 2'b00);
    chk("R11 memory kept", mem[2][63:32], 32'h1122_3344);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 64'd0;
    mem[1] = 64'h89AB_CDEF_0123_4567;
    mem[2] = 64'h1122_3344_5566_7788;
    mem_rdata = 64'd0;
    rst_n = 1'b0; req_valid = 1'b0; insn = 32'd0;
    rs1_val = 32'd0; rs2_val = 32'd0; rd_val = 32'd0; rd_pair_val = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #0.5;
    test_reset();
    test_agen();
    test_extend();
    test_pair_load();
    test_store();
    test_misalign();
    test_test_and_set();
    test_swap();
    test_decode();
    test_busy();
    idle_cycle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule